// File: doc/BRIEF.md
# Target-Side Common Command Decoder

This block sits inside a serial-bus target, behind the bit-level receiver. It watches a stream of already decoded bus events: START, repeated START, STOP, address bytes (seven address bits in [7:1], read/write bit in [0]) and data bytes. From that stream it picks out common command frames and decides whether each command is broadcast or directed. It also owns the target's dynamic address register.

Four address operations are supported:
- adopt the static address on a broadcast command;
- set the dynamic address directly from a data byte, naming the target by its static address;
- replace an assigned dynamic address with a new one;
- clear the dynamic address, either broadcast or directed.

Directed commands can address several targets in turn. Each is reached by a repeated START followed by its address, without sending the broadcast prologue again. A STOP ends that context.

The block outputs the current dynamic address, an address-valid flag, the last command code, and a one-cycle pulse for each decoded command code. Every output is registered, so an event accepted at one clock edge shows its effect just after that same edge.

Top module: `ccc_decoder`

## Requirements
- R1: During and after reset, `dyn_valid` is 0, `dyn_addr` is 0 and `ccc_pulse` is 0.
- R2: A frame is START, then an address byte of 0x7E with bit 0 = 0 (write), then a data byte that is the command code. `ccc_pulse` is high for exactly the cycle after the code byte, and `ccc_code` then holds that code. A 0x7E address with the read bit set, or any other address, produces no pulse and no command.
- R3: Broadcast code 0x29 loads `static_addr` into `dyn_addr` and sets `dyn_valid`.
- R4: Broadcast code 0x06 clears `dyn_valid` and leaves `dyn_addr` unchanged.
- R5: Codes with bit 7 set (0x80–0xFF) are directed. For code 0x87, the target is named by an address byte equal to `static_addr` after a repeated START. Bits [7:1] of the following data byte become `dyn_addr`, and `dyn_valid` is set. An address byte with any other value changes nothing.
- R6: Directed code 0x88 acts only when `dyn_valid` is 1 and the address byte equals `dyn_addr`. In that case the next data byte's bits [7:1] replace `dyn_addr`. Otherwise nothing changes.
- R7: Directed code 0x86 clears `dyn_valid` in the cycle after an address byte that equals a valid `dyn_addr`, whatever its read/write bit. Any other address leaves it set.
- R8: Within one directed command, each repeated START followed by an address selects a new target. An address of 0x7E (write) after a repeated START opens a new command frame instead.
- R9: A STOP ends the directed context. A later START followed by an address byte equal to the target is an ordinary transfer and applies no command.
- R10: A directed command consumes only the first data byte after a matching address. Later data bytes, and data bytes outside a command frame, change nothing and give no pulse.
- R11: An address written by one event is the one compared against the very next event, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| static_addr | input | 7 | Target's fixed address |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | 0 START, 1 repeated START, 2 STOP, 3 address byte, 4 data byte |
| ev_data | input | 8 | Byte of an address or data event |
| dyn_addr | output | 7 | Current dynamic address |
| dyn_valid | output | 1 | Dynamic address is assigned |
| ccc_pulse | output | 1 | One-cycle pulse after a command code byte |
| ccc_code | output | 8 | Last decoded command code |

## Verification
Two functions can meet in back-to-back cycles: the write of the address register and the comparison of a target address against it. The bench provokes this with a directed replace command. It writes a new address and, on the very next cycles, sends a repeated START and that new address, with no idle cycles between the events. The result is judged by whether the following data byte is accepted, which shows the comparison already used the freshly written value. The same-cycle case of a code pulse and an address clear, from the broadcast reset, is checked on the same sampled cycle.

// File: rtl/ccc_dec_pkg.sv
// Shared types for the common command decoder.
// Assumes event kinds are encoded as listed in the port description.
package ccc_dec_pkg;
    typedef enum logic [2:0] {
        EV_START  = 3'd0,
        EV_RSTART = 3'd1,
        EV_STOP   = 3'd2,
        EV_ADDR   = 3'd3,
        EV_DATA   = 3'd4
    } ev_kind_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CLEAR,
        OP_TAKE_STATIC,
        OP_TAKE_DATA
    } addr_op_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ADDR,
        FS_HDR,
        FS_BODY,
        FS_DWAIT,
        FS_DADDR,
        FS_DDATA,
        FS_DSKIP
    } frame_st_e;

    typedef enum logic [1:0] {
        MT_STATIC,
        MT_DYN,
        MT_ACTIVE
    } match_sel_e;
endpackage

// File: rtl/ccc_target_match.sv
// Compares an incoming target address with this target's identity.
// Assumes the caller selects which identity applies to the current command.
module ccc_target_match #(
    parameter int AW = 7
) (
    input  ccc_dec_pkg::match_sel_e sel,
    input  logic [AW-1:0]           addr_in,
    input  logic [AW-1:0]           static_addr,
    input  logic [AW-1:0]           dyn_addr,
    input  logic                    dyn_valid,
    output logic                    hit
);
    import ccc_dec_pkg::*;

    // Pick the comparison rule for the current command.
    always_comb begin
        unique case (sel)
            MT_STATIC: hit = (addr_in == static_addr);
            MT_DYN:    hit = dyn_valid && (addr_in == dyn_addr);
            default:   hit = dyn_valid ? (addr_in == dyn_addr)
                                       : (addr_in == static_addr);
        endcase
    end
endmodule

// File: rtl/ccc_addr_reg.sv
// Holds the dynamic address and its valid flag.
// Assumes at most one operation is requested per cycle.
module ccc_addr_reg #(
    parameter int AW = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ccc_dec_pkg::addr_op_e op,
    input  logic [AW-1:0]         static_addr,
    input  logic [AW-1:0]         new_addr,
    output logic [AW-1:0]         dyn_addr,
    output logic                  dyn_valid
);
    import ccc_dec_pkg::*;

    // Apply the requested address operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dyn_addr  <= '0;
            dyn_valid <= 1'b0;
        end else begin
            unique case (op)
                OP_CLEAR:       dyn_valid <= 1'b0;
                OP_TAKE_STATIC: begin dyn_addr <= static_addr; dyn_valid <= 1'b1; end
                OP_TAKE_DATA:   begin dyn_addr <= new_addr;    dyn_valid <= 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ccc_frame_fsm.sv
// Tracks command framing on the event stream and issues address operations.
// Assumes address bytes carry the address in [7:1] and read/write in [0].
module ccc_frame_fsm #(
    parameter int         AW           = 7,
    parameter logic [7:0] C_BC_RESET   = 8'h06,
    parameter logic [7:0] C_BC_STATIC  = 8'h29,
    parameter logic [7:0] C_DIR_RESET  = 8'h86,
    parameter logic [7:0] C_SET_STATIC = 8'h87,
    parameter logic [7:0] C_SET_NEW    = 8'h88,
    parameter logic [AW-1:0] BCAST_ADDR = 7'h7E
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    input  ccc_dec_pkg::ev_kind_e     ev_kind,
    input  logic [AW:0]               ev_data,
    input  logic                      tgt_hit,
    output ccc_dec_pkg::match_sel_e   match_sel,
    output ccc_dec_pkg::addr_op_e     op,
    output logic                      ccc_pulse,
    output logic [AW:0]               ccc_code
);
    import ccc_dec_pkg::*;
    localparam int DW = AW + 1;

    frame_st_e     st, st_nx;
    logic [DW-1:0] code_nx;
    logic          pulse_nx;
    logic          in_dir;
    logic          is_bcast_w;

    // Decode context and broadcast header.
    always_comb begin
        in_dir     = (st == FS_DWAIT) || (st == FS_DADDR) ||
                     (st == FS_DDATA) || (st == FS_DSKIP);
        is_bcast_w = (ev_data[DW-1:1] == BCAST_ADDR) && !ev_data[0];
        if (ccc_code == C_SET_STATIC)
            match_sel = MT_STATIC;
        else if (ccc_code == C_SET_NEW || ccc_code == C_DIR_RESET)
            match_sel = MT_DYN;
        else
            match_sel = MT_ACTIVE;
    end

    // Next frame state, command code and address operation.
    always_comb begin
        st_nx    = st;
        code_nx  = ccc_code;
        op       = OP_NONE;
        pulse_nx = 1'b0;
        if (ev_valid) begin
            unique case (ev_kind)
                EV_START:  st_nx = FS_ADDR;
                EV_RSTART: st_nx = in_dir ? FS_DADDR : FS_ADDR;
                EV_STOP:   st_nx = FS_IDLE;
                EV_ADDR: begin
                    if (st == FS_ADDR) begin
                        st_nx = is_bcast_w ? FS_HDR : FS_IDLE;
                    end else if (st == FS_DADDR) begin
                        if (is_bcast_w) begin
                            st_nx = FS_HDR;
                        end else if (tgt_hit) begin
                            st_nx = FS_DDATA;
                            if (ccc_code == C_DIR_RESET) op = OP_CLEAR;
                        end else begin
                            st_nx = FS_DSKIP;
                        end
                    end
                end
                EV_DATA: begin
                    if (st == FS_HDR) begin
                        code_nx  = ev_data;
                        pulse_nx = 1'b1;
                        if (ev_data[DW-1]) begin
                            st_nx = FS_DWAIT;
                        end else begin
                            st_nx = FS_BODY;
                            if (ev_data == C_BC_RESET)       op = OP_CLEAR;
                            else if (ev_data == C_BC_STATIC) op = OP_TAKE_STATIC;
                        end
                    end else if (st == FS_DDATA) begin
                        st_nx = FS_DSKIP;
                        if (ccc_code == C_SET_STATIC || ccc_code == C_SET_NEW)
                            op = OP_TAKE_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register state, code and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FS_IDLE;
            ccc_code  <= '0;
            ccc_pulse <= 1'b0;
        end else begin
            st        <= st_nx;
            ccc_code  <= code_nx;
            ccc_pulse <= pulse_nx;
        end
    end
endmodule

// File: rtl/ccc_decoder.sv
// Top of the target-side common command decoder.
// Assumes one event per cycle at most, already decoded from the bus pins.
module ccc_decoder #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] static_addr,
    input  logic          ev_valid,
    input  logic [2:0]    ev_kind,
    input  logic [AW:0]   ev_data,
    output logic [AW-1:0] dyn_addr,
    output logic          dyn_valid,
    output logic          ccc_pulse,
    output logic [AW:0]   ccc_code
);
    import ccc_dec_pkg::*;

    match_sel_e msel;
    addr_op_e   op;
    logic       hit;

    ccc_target_match #(.AW(AW)) match_i (
        .sel(msel), .addr_in(ev_data[AW:1]), .static_addr(static_addr),
        .dyn_addr(dyn_addr), .dyn_valid(dyn_valid), .hit(hit)
    );

    ccc_frame_fsm #(.AW(AW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
        .ev_kind(ev_kind_e'(ev_kind)), .ev_data(ev_data), .tgt_hit(hit),
        .match_sel(msel), .op(op), .ccc_pulse(ccc_pulse), .ccc_code(ccc_code)
    );

    ccc_addr_reg #(.AW(AW)) areg_i (
        .clk(clk), .rst_n(rst_n), .op(op), .static_addr(static_addr),
        .new_addr(ev_data[AW:1]), .dyn_addr(dyn_addr), .dyn_valid(dyn_valid)
    );
endmodule

// File: rtl/ccc_decoder_chk.sv
// Property checker for the command decoder, attached by bind.
module ccc_decoder_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_valid,
    input logic [2:0]    ev_kind,
    input logic [AW:0]   ev_data,
    input logic [AW-1:0] dyn_addr,
    input logic          dyn_valid,
    input logic          ccc_pulse,
    input logic [AW:0]   ccc_code
);
    // R2: a pulse follows a data event whose byte is the reported code
    p_pulse_from_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ccc_pulse |-> ($past(ev_valid) && $past(ev_kind) == 3'd4 &&
                       $past(ev_data) == ccc_code));

    // R2: pulse lasts one cycle when no further event arrives
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ccc_pulse && !ev_valid) |=> !ccc_pulse);

    // R10: address only moves after a data event
    p_addr_moves_on_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && (ev_kind == 3'd4)) |=> $stable(dyn_addr));

    // R3: valid flag rises only after a data event
    p_valid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dyn_valid) |-> ($past(ev_valid) && $past(ev_kind) == 3'd4));

    // R7: valid flag falls only after an address or data event
    p_valid_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dyn_valid) |-> ($past(ev_valid) &&
                              ($past(ev_kind) == 3'd3 || $past(ev_kind) == 3'd4)));

    // R9: a STOP never produces a pulse
    p_stop_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 3'd2) |=> !ccc_pulse);
endmodule

bind ccc_decoder ccc_decoder_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_data(ev_data), .dyn_addr(dyn_addr), .dyn_valid(dyn_valid),
    .ccc_pulse(ccc_pulse), .ccc_code(ccc_code)
);

// File: tb/ccc_decoder_tb_top.sv
module ccc_decoder_tb_top;
    import ccc_dec_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] static_addr = 7'h35;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_kind = 3'd0;
    logic [7:0] ev_data = 8'h00;
    logic [6:0] dyn_addr;
    logic       dyn_valid;
    logic       ccc_pulse;
    logic [7:0] ccc_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccc_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .static_addr(static_addr),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data),
        .dyn_addr(dyn_addr), .dyn_valid(dyn_valid),
        .ccc_pulse(ccc_pulse), .ccc_code(ccc_code)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Present one event for one cycle; called at a falling edge.
    task automatic ev(input logic [2:0] k, input logic [7:0] d);
        ev_valid = 1'b1; ev_kind = k; ev_data = d;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic adr(input logic [6:0] a, input logic rnw);
        ev(EV_ADDR, {a, rnw});
    endtask

    task automatic hdr(input logic [7:0] code);
        ev(EV_START, 8'h00);
        adr(7'h7E, 1'b0);
        ev(EV_DATA, code);
    endtask

    task automatic t_reset;
        chk("R1 valid", {7'd0, dyn_valid}, 8'h00);
        chk("R1 addr", {1'b0, dyn_addr}, 8'h00);
        chk("R1 pulse", {7'd0, ccc_pulse}, 8'h00);
    endtask

    task automatic t_static_and_frame;
        hdr(8'h29);
        chk("R2 pulse", {7'd0, ccc_pulse}, 8'h01);
        chk("R2 code", ccc_code, 8'h29);
        chk("R3 addr", {1'b0, dyn_addr}, 8'h35);
        chk("R3 valid", {7'd0, dyn_valid}, 8'h01);
        ev(EV_STOP, 8'h00);
        chk("R2 pulse one cycle", {7'd0, ccc_pulse}, 8'h00);
        ev(EV_START, 8'h00); adr(7'h7E, 1'b1); ev(EV_DATA, 8'h06);
        chk("R2 read bcast no pulse", {7'd0, ccc_pulse}, 8'h00);
        chk("R2 read bcast no clear", {7'd0, dyn_valid}, 8'h01);
        ev(EV_STOP, 8'h00);
        ev(EV_START, 8'h00); adr(7'h35, 1'b0); ev(EV_DATA, 8'h06);
        chk("R2 plain addr no pulse", {7'd0, ccc_pulse}, 8'h00);
        chk("R10 plain data no clear", {7'd0, dyn_valid}, 8'h01);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_bcast_reset;
        hdr(8'h06);
        chk("R4 pulse", {7'd0, ccc_pulse}, 8'h01);
        chk("R4 valid cleared", {7'd0, dyn_valid}, 8'h00);
        chk("R4 addr kept", {1'b0, dyn_addr}, 8'h35);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_set_from_static;
        hdr(8'h87);
        chk("R5 directed code", ccc_code, 8'h87);
        ev(EV_RSTART, 8'h00); adr(7'h11, 1'b0); ev(EV_DATA, {7'h20, 1'b0});
        chk("R5 other target", {7'd0, dyn_valid}, 8'h00);
        ev(EV_RSTART, 8'h00); adr(7'h35, 1'b0); ev(EV_DATA, {7'h42, 1'b0});
        chk("R5 addr loaded", {1'b0, dyn_addr}, 8'h42);
        chk("R5 valid set", {7'd0, dyn_valid}, 8'h01);
        ev(EV_DATA, {7'h50, 1'b0});
        chk("R10 extra data ignored", {1'b0, dyn_addr}, 8'h42);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_set_new;
        hdr(8'h88);
        ev(EV_RSTART, 8'h00); adr(7'h35, 1'b0); ev(EV_DATA, {7'h10, 1'b0});
        chk("R6 static not matched", {1'b0, dyn_addr}, 8'h42);
        ev(EV_RSTART, 8'h00); adr(7'h42, 1'b0); ev(EV_DATA, {7'h23, 1'b0});
        chk("R6 replaced", {1'b0, dyn_addr}, 8'h23);
        ev(EV_RSTART, 8'h00); adr(7'h23, 1'b0); ev(EV_DATA, {7'h24, 1'b0});
        chk("R11 back-to-back match", {1'b0, dyn_addr}, 8'h24);
        chk("R8 second target", {7'd0, dyn_valid}, 8'h01);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_dir_reset;
        hdr(8'h86);
        ev(EV_RSTART, 8'h00); adr(7'h35, 1'b0);
        chk("R7 other addr kept", {7'd0, dyn_valid}, 8'h01);
        ev(EV_RSTART, 8'h00); adr(7'h24, 1'b1);
        chk("R7 cleared", {7'd0, dyn_valid}, 8'h00);
        ev(EV_STOP, 8'h00);
        hdr(8'h88);
        ev(EV_RSTART, 8'h00); adr(7'h35, 1'b0); ev(EV_DATA, {7'h33, 1'b0});
        chk("R6 no valid no load", {7'd0, dyn_valid}, 8'h00);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_new_frame;
        hdr(8'h29);
        hdr(8'h88);
        ev(EV_RSTART, 8'h00); adr(7'h7E, 1'b0); ev(EV_DATA, 8'h06);
        chk("R8 new frame pulse", {7'd0, ccc_pulse}, 8'h01);
        chk("R8 new frame code", ccc_code, 8'h06);
        chk("R8 new frame applied", {7'd0, dyn_valid}, 8'h00);
        ev(EV_STOP, 8'h00);
    endtask

    task automatic t_stop_ends;
        hdr(8'h29);
        ev(EV_STOP, 8'h00);
        hdr(8'h86);
        ev(EV_STOP, 8'h00);
        ev(EV_START, 8'h00); adr(7'h35, 1'b0);
        chk("R9 no directed after stop", {7'd0, dyn_valid}, 8'h01);
        ev(EV_DATA, 8'h00);
        chk("R9 addr unchanged", {1'b0, dyn_addr}, 8'h35);
        ev(EV_STOP, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static_and_frame();
        t_bcast_reset();
        t_set_from_static();
        t_set_new();
        t_dir_reset();
        t_new_frame();
        t_stop_ends();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule